// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM device from power-on to a usable state. After reset it holds the command pins at a quiet, stable level for a programmable number of clock cycles, with the clock enable low. It then raises the clock enable, closes every bank, runs a fixed series of auto-refresh commands and writes the device mode register. Each command is followed by the minimum gap the device needs. When the last gap has passed, the sequencer raises a done flag and leaves the pins idle so the normal access logic can take over.

All delays are given in clock cycles through parameters. The data bus is not driven. The byte masks stay high the whole time. Each gap is counted from the cycle that carries the command, so with a gap of G the next command appears exactly G cycles later. Reset is asserted asynchronously and released through a two-stage synchronizer. This adds two cycles before the stable-wait count begins.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is asserted, sdr_cke is 0, the pins carry the idle encoding {cs_n,ras_n,cas_n,we_n} = 0111, sdr_dqm is all ones and init_done is 0.
- R2: After reset is released, sdr_cke stays 0 and only idle cycles appear for WAIT_CYC+2 cycles: two synchronizer cycles plus WAIT_CYC cycles of wait. No command is issued while sdr_cke is 0.
- R3: sdr_cke rises exactly one cycle before the bank-close command and then stays 1.
- R4: The first command is bank-close-all, encoded 0010, with address bit 10 at 1.
- R5: The first auto-refresh follows the bank-close command by exactly T_RP cycles.
- R6: Exactly NUM_REF auto-refresh commands (encoding 0001) are issued, each following the previous one by exactly T_RC cycles.
- R7: A load-mode command (encoding 0000) follows the last refresh by exactly T_RC cycles, with MODE_VAL on sdr_addr.
- R8: init_done rises exactly T_MRD cycles after the load-mode command and then stays 1. Only idle cycles follow it.
- R9: Every cycle that carries none of the commands above uses the idle encoding, and sdr_dqm stays all ones throughout.
- R10: Asserting reset in the middle of the sequence returns the pins to the R1 state at once, and the whole sequence then runs again from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdr_cke | output | 1 | Clock enable to the device |
| sdr_cs_n | output | 1 | Chip select, active low |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_addr | output | ADDR_W | Address lines (bit 10 at bank-close, mode value at load-mode) |
| sdr_dqm | output | DQM_W | Byte masks, held high |
| init_done | output | 1 | Sequence complete, normal access may start |

## Verification
The hardest case to reach from the ports is a reset that lands partway through the refresh series. That reset has to clear the refresh count and the gap timer, not just the state. The bench waits for the third refresh, pulls reset low asynchronously, checks the idle pin state, and then replays the whole command trace. The replay must again show exactly the expected number of refreshes at the same cycle offsets. Every command's cycle is measured from reset release and compared with a table derived from the gap parameters. This exposes both short and long gaps.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PRE_ALL,
    CMD_AUTO_REF,
    CMD_LOAD_MODE
  } sdr_cmd_e;

  typedef enum logic [3:0] {
    ST_WAIT,
    ST_CKE_UP,
    ST_PRE,
    ST_PRE_GAP,
    ST_REF,
    ST_REF_GAP,
    ST_LMR,
    ST_LMR_GAP,
    ST_DONE
  } seq_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_cmd_encoder.sv
module sdram_cmd_encoder
  import sdram_init_pkg::*;
(
  input  sdr_cmd_e cmd,
  output logic     cs_n,
  output logic     ras_n,
  output logic     cas_n,
  output logic     we_n
);

  always_comb begin
    cs_n = 1'b0;
    unique case (cmd)
      CMD_PRE_ALL:   {ras_n, cas_n, we_n} = 3'b010;
      CMD_AUTO_REF:  {ras_n, cas_n, we_n} = 3'b001;
      CMD_LOAD_MODE: {ras_n, cas_n, we_n} = 3'b000;
      default:       {ras_n, cas_n, we_n} = 3'b111;
    endcase
  end

endmodule

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load | ~zero;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= W'(RST_VAL);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_TMR_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero); // R5

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W   = 13,
  parameter int unsigned DQM_W    = 2,
  parameter int unsigned WAIT_CYC = 20000,
  parameter int unsigned T_RP     = 2,
  parameter int unsigned T_RC     = 7,
  parameter int unsigned T_MRD    = 2,
  parameter int unsigned NUM_REF  = 8,
  parameter logic [ADDR_W-1:0] MODE_VAL = ADDR_W'(12'h033)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              sdr_cke,
  output logic              sdr_cs_n,
  output logic              sdr_ras_n,
  output logic              sdr_cas_n,
  output logic              sdr_we_n,
  output logic [ADDR_W-1:0] sdr_addr,
  output logic [DQM_W-1:0]  sdr_dqm,
  output logic              init_done
);

  localparam int unsigned MAXV = max2(max2(WAIT_CYC, T_RP), max2(T_RC, T_MRD));
  localparam int unsigned TW   = $clog2(MAXV + 1);
  localparam int unsigned RW   = $clog2(NUM_REF + 1);
  localparam logic [TW-1:0] RP_LD  = TW'(T_RP - 2);
  localparam logic [TW-1:0] RC_LD  = TW'(T_RC - 2);
  localparam logic [TW-1:0] MRD_LD = TW'(T_MRD - 2);
  localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1) << 10;

  // reset synchronizer: asynchronous assert, synchronous release
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  seq_state_e    state_q, state_d;
  logic [RW-1:0] ref_cnt_q, ref_cnt_d;
  logic          ref_cnt_en;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  sdr_cmd_e      cmd;

  sdram_gap_timer #(.W(TW), .RST_VAL(WAIT_CYC - 1)) u_timer (
    .clk      (clk),
    .rst_n    (rst_s),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  always_comb begin
    state_d    = state_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    ref_cnt_en = 1'b0;
    ref_cnt_d  = ref_cnt_q + RW'(1);
    unique case (state_q)
      ST_WAIT:    if (tmr_zero) state_d = ST_CKE_UP;
      ST_CKE_UP:  state_d = ST_PRE;
      ST_PRE: begin
        tmr_load = 1'b1;
        tmr_val  = RP_LD;
        state_d  = ST_PRE_GAP;
      end
      ST_PRE_GAP: if (tmr_zero) state_d = ST_REF;
      ST_REF: begin
        tmr_load   = 1'b1;
        tmr_val    = RC_LD;
        ref_cnt_en = 1'b1;
        state_d    = ST_REF_GAP;
      end
      ST_REF_GAP: if (tmr_zero) state_d = (ref_cnt_q == RW'(NUM_REF)) ? ST_LMR : ST_REF;
      ST_LMR: begin
        tmr_load = 1'b1;
        tmr_val  = MRD_LD;
        state_d  = ST_LMR_GAP;
      end
      ST_LMR_GAP: if (tmr_zero) state_d = ST_DONE;
      default:    state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) state_q <= ST_WAIT;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)          ref_cnt_q <= '0;
    else if (ref_cnt_en) ref_cnt_q <= ref_cnt_d;
  end

  always_comb begin
    unique case (state_q)
      ST_PRE:  cmd = CMD_PRE_ALL;
      ST_REF:  cmd = CMD_AUTO_REF;
      ST_LMR:  cmd = CMD_LOAD_MODE;
      default: cmd = CMD_NOP;
    endcase
  end

  sdram_cmd_encoder u_enc (
    .cmd   (cmd),
    .cs_n  (sdr_cs_n),
    .ras_n (sdr_ras_n),
    .cas_n (sdr_cas_n),
    .we_n  (sdr_we_n)
  );

  always_comb begin
    unique case (state_q)
      ST_PRE:  sdr_addr = PRE_ADDR;
      ST_LMR:  sdr_addr = MODE_VAL;
      default: sdr_addr = '0;
    endcase
  end

  assign sdr_cke   = (state_q != ST_WAIT);
  assign sdr_dqm   = '1;
  assign init_done = (state_q == ST_DONE);

  logic [3:0] pins;
  assign pins = {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n};

  AST_NOP_WHILE_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_s)
    !sdr_cke |-> (pins == 4'b0111)); // R2
  AST_CKE_HOLDS: assert property (@(posedge clk) disable iff (!rst_s)
    sdr_cke |=> sdr_cke); // R3
  AST_PRE_A10_HIGH: assert property (@(posedge clk) disable iff (!rst_s)
    (pins == 4'b0010) |-> sdr_addr[10]); // R4
  AST_LMR_AFTER_ALL_REF: assert property (@(posedge clk) disable iff (!rst_s)
    (pins == 4'b0000) |-> (ref_cnt_q == RW'(NUM_REF))); // R6
  AST_REF_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_s)
    ref_cnt_q <= RW'(NUM_REF)); // R6
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_s)
    init_done |=> init_done); // R8
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_s)
    init_done |-> (pins == 4'b0111)); // R8

endmodule

// File: tb/sdram_powerup_seq_test.sv
module sdram_powerup_seq_test;

  localparam int WAIT  = 20;
  localparam int RP    = 2;
  localparam int RC    = 7;
  localparam int MRD   = 2;
  localparam int SYNC  = 2;
  localparam int NEV   = 10;
  localparam logic [12:0] MODE = 13'h0033;
  localparam int PRE_AT  = WAIT + SYNC + 1;
  localparam int REF0_AT = PRE_AT + RP;
  localparam int LMR_AT  = REF0_AT + 8 * RC;
  localparam int DONE_AT = LMR_AT + MRD;

  // expected command trace: code {cs_n,ras_n,cas_n,we_n} and cycle after reset release
  localparam int EXP_CODE [NEV] = '{2, 1, 1, 1, 1, 1, 1, 1, 1, 0};
  localparam int EXP_CYC  [NEV] = '{PRE_AT, REF0_AT, REF0_AT + RC, REF0_AT + 2*RC,
                                    REF0_AT + 3*RC, REF0_AT + 4*RC, REF0_AT + 5*RC,
                                    REF0_AT + 6*RC, REF0_AT + 7*RC, LMR_AT};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, done;
  logic [12:0] addr;
  logic [1:0]  dqm;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sdram_powerup_seq #(
    .ADDR_W(13), .DQM_W(2), .WAIT_CYC(WAIT), .T_RP(RP), .T_RC(RC),
    .T_MRD(MRD), .NUM_REF(8), .MODE_VAL(MODE)
  ) uut (
    .clk(clk), .rst_n(rst_n), .sdr_cke(cke), .sdr_cs_n(cs_n), .sdr_ras_n(ras_n),
    .sdr_cas_n(cas_n), .sdr_we_n(we_n), .sdr_addr(addr), .sdr_dqm(dqm), .init_done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_reset_state(input string tag);
    check(cke == 1'b0, {tag, " cke"}, cke, 0);
    check({cs_n, ras_n, cas_n, we_n} == 4'b0111, {tag, " pins idle"}, {cs_n, ras_n, cas_n, we_n}, 7);
    check(dqm == 2'b11, {tag, " dqm"}, dqm, 3);
    check(done == 1'b0, {tag, " done"}, done, 0);
  endtask

  // walks the sequence from reset release; stop_at_ref > 0 aborts after that refresh
  task automatic run_seq(input int stop_at_ref);
    int ev_code [16];
    int ev_cyc  [16];
    int n_ev = 0;
    int n_ref = 0;
    int cke_rise = -1;
    int done_at = -1;
    bit cke_bad = 0;
    bit late_cmd = 0;
    bit done_drop = 0;
    bit dqm_bad = 0;
    logic [12:0] pre_addr = '0;
    logic [12:0] lmr_addr = '0;
    for (int k = 0; k < 400; k++) begin
      int code;
      code = {cs_n, ras_n, cas_n, we_n};
      if (!cke && code != 7) cke_bad = 1;
      if (cke && cke_rise < 0) cke_rise = k;
      if (cke_rise >= 0 && !cke) cke_bad = 1;
      if (dqm != 2'b11) dqm_bad = 1;
      if (code != 7) begin
        if (n_ev < 16) begin
          ev_code[n_ev] = code;
          ev_cyc[n_ev]  = k;
        end
        if (code == 2) pre_addr = addr;
        if (code == 0) lmr_addr = addr;
        if (code == 1) n_ref++;
        if (done_at >= 0) late_cmd = 1;
        n_ev++;
      end
      if (done && done_at < 0) done_at = k;
      if (done_at >= 0 && !done) done_drop = 1;
      if (stop_at_ref > 0 && n_ref == stop_at_ref) break;
      if (done_at >= 0 && k >= done_at + 12) break;
      @(posedge clk);
      @(negedge clk);
    end
    if (stop_at_ref > 0) return;
    check(!cke_bad, "R2 no command and cke low during stable wait", cke_bad, 0);
    check(cke_rise == PRE_AT - 1, "R3 cke rise cycle", cke_rise, PRE_AT - 1);
    check(n_ev == NEV, "R9 number of non-idle cycles", n_ev, NEV);
    for (int i = 0; i < NEV && i < n_ev; i++) begin
      string req;
      req = (i == 0) ? "R4" : (i == 1) ? "R5" : (i == NEV - 1) ? "R7" : "R6";
      check(ev_code[i] == EXP_CODE[i], $sformatf("%s command code #%0d", req, i), ev_code[i], EXP_CODE[i]);
      check(ev_cyc[i] == EXP_CYC[i], $sformatf("%s command cycle #%0d", req, i), ev_cyc[i], EXP_CYC[i]);
    end
    check(n_ref == 8, "R6 refresh count", n_ref, 8);
    check(pre_addr[10] == 1'b1, "R4 A10 at bank-close", pre_addr[10], 1);
    check(lmr_addr == MODE, "R7 mode value on address", lmr_addr, MODE);
    check(done_at == DONE_AT, "R8 done cycle", done_at, DONE_AT);
    check(!done_drop, "R8 done stays high", done_drop, 0);
    check(!late_cmd, "R8 only idle after done", late_cmd, 0);
    check(!dqm_bad, "R9 dqm all ones", dqm_bad, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL R8 watchdog expired before done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state("R1 reset");
    rst_n = 1'b1;
    #1;
    run_seq(0);

    // reset in the middle of the refresh series
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    run_seq(3);
    #2;
    rst_n = 1'b0;
    #1;
    check_reset_state("R10 mid-sequence reset");
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    run_seq(0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule